// File: doc/BRIEF.md
# Wakeup-Free Latency-Countdown Issue Queue

This block holds instructions whose issue cycle was predicted before they arrive. No result tag is broadcast to the entries. Each entry carries a predicted remaining latency that a private counter decrements once per clock. When the counter reaches zero, the entry looks up its two source registers in a table of register ready bits. It raises a selection request only after both sources are seen ready. This check keeps instructions that are not truly ready off the issue ports.

Each entry is a small state machine with four states:
- FREE: the slot is unused.
- WAIT: the latency counter is still running.
- CHECK: the latency is zero and the entry looks up the ready bits every cycle.
- REQ: the sources are ready and the entry is requesting issue.

The entry moves through these transitions:
- FREE to WAIT: dispatch with a latency above zero.
- FREE to CHECK: dispatch with a latency of zero.
- WAIT to CHECK: the counter steps from 1 to 0.
- CHECK to REQ: both source bits are set.
- REQ to FREE: the entry is granted.

The queue collapses every cycle, so occupied slots always sit at the low indices in age order. A selector grants the oldest requesters, up to the issue width. Dispatch is all-or-nothing per cycle and stalls when too few slots are free. The same register table takes set strobes from the writeback ports and clear strobes from the destinations of accepted dispatches.

Top module: `wf_issue_queue`

## Requirements
- R1: After reset the queue is empty, no issue lane is valid, `disp_full` is low, and every register is marked ready.
- R2: A dispatch is accepted when `disp_full` is low. Each valid lane becomes one entry, and the entries are appended behind the existing entries in ascending lane order. An invalid lane leaves no gap.
- R3: `disp_full` is high when the occupancy at the start of the cycle exceeds DEPTH minus DISP_W. While it is high, the whole dispatch group is ignored and never issues.
- R4: An entry dispatched at clock edge e with latency L first looks up its sources in the cycle after edge e+L. With ready sources, it can appear on an issue lane in the cycle after edge e+L+1.
- R5: An entry requests issue only when both source registers read as ready in a cycle in which it is in CHECK. Otherwise it stays in CHECK and looks again every cycle. After a writeback at edge w sets its last missing source, it issues in the cycle after edge w+1.
- R6: At most ISSUE_W entries are granted per cycle. Grants go to requesting entries oldest first, and issue lane k carries the k-th oldest granted entry, with lanes filled from 0 upward.
- R7: A granted entry leaves the queue at the next edge, never issues again, and frees its slot for later dispatch. The remaining entries keep their relative order.
- R8: A writeback sets the ready bit of its register. An accepted dispatch clears the bit of its destination register. When both hit the same register in the same cycle, the bit ends clear.
- R9: Each valid issue lane carries the tag the entry was dispatched with.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| disp_valid | input | DISP_W | Per-lane dispatch valid |
| disp_lat | input | DISP_W*LAT_W | Predicted latency per lane |
| disp_src_a | input | DISP_W*RW | First source register per lane |
| disp_src_b | input | DISP_W*RW | Second source register per lane |
| disp_dst | input | DISP_W*RW | Destination register per lane (cleared in the ready table) |
| disp_tag | input | DISP_W*TAG_W | Instruction tag per lane |
| disp_full | output | 1 | Dispatch stall; the group is not taken |
| wb_valid | input | WB_W | Writeback strobe per port |
| wb_reg | input | WB_W*RW | Register written back per port |
| iss_valid | output | ISSUE_W | Issue lane valid |
| iss_tag | output | ISSUE_W*TAG_W | Tag on each issue lane |

## Verification
The bench sends more ready entries than there are issue lanes in a single cycle. A selector that is not oldest-first, or that packs the lanes wrongly, then shows the younger group early or puts tags on the wrong lanes. It holds consumers of a register that was just renamed, and it renames a register in the same cycle as a writeback to it. A table that let the set win would issue a consumer whose producer has not finished. It fills the queue to capacity and tries one more dispatch. A design that checked the wrong threshold, or partly accepted the group, would issue that stray tag. It also checks the exact cycle of issue from the dispatch latency, which exposes an off-by-one in the countdown.

// File: rtl/wfq_pkg.sv
package wfq_pkg;
    typedef enum logic [1:0] {
        ST_FREE  = 2'd0,
        ST_WAIT  = 2'd1,
        ST_CHECK = 2'd2,
        ST_REQ   = 2'd3
    } ent_state_t;
endpackage

// File: rtl/wfq_entry_fsm.sv
module wfq_entry_fsm
    import wfq_pkg::*;
#(
    parameter int LAT_W = 4
) (
    input  ent_state_t        st_cur,
    input  logic [LAT_W-1:0]  lat_cur,
    input  logic              srcs_rdy,
    output ent_state_t        st_nxt,
    output logic [LAT_W-1:0]  lat_nxt
);
    localparam logic [LAT_W-1:0] ONE = LAT_W'(1);

    always_comb begin
        st_nxt  = st_cur;
        lat_nxt = lat_cur;
        unique case (st_cur)
            ST_FREE: begin
                st_nxt = ST_FREE;
            end
            ST_WAIT: begin
                lat_nxt = lat_cur - ONE;
                st_nxt  = (lat_cur == ONE) ? ST_CHECK : ST_WAIT;
            end
            ST_CHECK: begin
                st_nxt = srcs_rdy ? ST_REQ : ST_CHECK;
            end
            ST_REQ: begin
                st_nxt = ST_REQ;
            end
            default: st_nxt = ST_FREE;
        endcase
    end
endmodule

// File: rtl/wfq_ready_table.sv
module wfq_ready_table #(
    parameter int NREG  = 32,
    parameter int WB_W  = 2,
    parameter int CLR_W = 4,
    localparam int RW   = $clog2(NREG)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [WB_W-1:0]            wb_valid,
    input  logic [WB_W-1:0][RW-1:0]    wb_reg,
    input  logic [CLR_W-1:0]           clr_valid,
    input  logic [CLR_W-1:0][RW-1:0]   clr_reg,
    output logic [NREG-1:0]            rdy
);
    logic [NREG-1:0] rdy_q, rdy_d;

    always_comb begin
        rdy_d = rdy_q;
        for (int p = 0; p < WB_W; p++) begin
            if (wb_valid[p]) rdy_d[wb_reg[p]] = 1'b1;
        end
        for (int c = 0; c < CLR_W; c++) begin
            if (clr_valid[c]) rdy_d[clr_reg[c]] = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) rdy_q <= '1;
        else        rdy_q <= rdy_d;
    end

    assign rdy = rdy_q;

    AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        clr_valid[0] |=> !rdy_q[$past(clr_reg[0])]) else $error("clear lost"); // R8

    AST_WB_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_valid[0] && (clr_valid == '0)) |=> rdy_q[$past(wb_reg[0])]) else $error("set lost"); // R8
endmodule

// File: rtl/wfq_select.sv
module wfq_select #(
    parameter int N      = 8,
    parameter int W      = 4,
    localparam int IDXW  = $clog2(N)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [N-1:0]            req,
    output logic [N-1:0]            grant,
    output logic [W-1:0]            out_valid,
    output logic [W-1:0][IDXW-1:0]  out_idx
);
    always_comb begin
        int taken;
        taken     = 0;
        grant     = '0;
        out_valid = '0;
        out_idx   = '0;
        for (int i = 0; i < N; i++) begin
            if (req[i] && taken < W) begin
                grant[i]         = 1'b1;
                out_valid[taken] = 1'b1;
                out_idx[taken]   = IDXW'(i);
                taken            = taken + 1;
            end
        end
    end

    AST_ISSUE_CAP: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(grant) <= W) else $error("too many grants"); // R6

    AST_GRANT_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        (grant & ~req) == '0) else $error("grant without request"); // R5

    AST_NO_IDLE_PORT: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(grant) < W) |-> (grant == req)) else $error("requester left waiting"); // R6
endmodule

// File: rtl/wf_issue_queue.sv
module wf_issue_queue
    import wfq_pkg::*;
#(
    parameter int DEPTH   = 8,
    parameter int ISSUE_W = 4,
    parameter int DISP_W  = 4,
    parameter int NREG    = 32,
    parameter int WB_W    = 2,
    parameter int LAT_W   = 4,
    parameter int TAG_W   = 8,
    localparam int RW     = $clog2(NREG),
    localparam int IDXW   = $clog2(DEPTH),
    localparam int CNTW   = $clog2(DEPTH + 1)
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic [DISP_W-1:0]               disp_valid,
    input  logic [DISP_W-1:0][LAT_W-1:0]    disp_lat,
    input  logic [DISP_W-1:0][RW-1:0]       disp_src_a,
    input  logic [DISP_W-1:0][RW-1:0]       disp_src_b,
    input  logic [DISP_W-1:0][RW-1:0]       disp_dst,
    input  logic [DISP_W-1:0][TAG_W-1:0]    disp_tag,
    output logic                            disp_full,
    input  logic [WB_W-1:0]                 wb_valid,
    input  logic [WB_W-1:0][RW-1:0]         wb_reg,
    output logic [ISSUE_W-1:0]              iss_valid,
    output logic [ISSUE_W-1:0][TAG_W-1:0]   iss_tag
);
    localparam logic [CNTW-1:0] FULL_AT = CNTW'(DEPTH - DISP_W);

    ent_state_t             st_q [DEPTH];
    ent_state_t             st_n [DEPTH];
    ent_state_t             st_d [DEPTH];
    logic [LAT_W-1:0]       lat_q [DEPTH];
    logic [LAT_W-1:0]       lat_n [DEPTH];
    logic [LAT_W-1:0]       lat_d [DEPTH];
    logic [RW-1:0]          sa_q [DEPTH];
    logic [RW-1:0]          sa_d [DEPTH];
    logic [RW-1:0]          sb_q [DEPTH];
    logic [RW-1:0]          sb_d [DEPTH];
    logic [TAG_W-1:0]       tag_q [DEPTH];
    logic [TAG_W-1:0]       tag_d [DEPTH];
    logic [CNTW-1:0]        cnt_q, cnt_d;

    logic [NREG-1:0]        rdy;
    logic [DEPTH-1:0]       req, grant;
    logic [ISSUE_W-1:0][IDXW-1:0] sel_idx;
    logic                   accept;
    logic [DISP_W-1:0]      clr_valid;

    assign disp_full = (cnt_q > FULL_AT);
    assign accept    = !disp_full;
    assign clr_valid = disp_valid & {DISP_W{accept}};

    wfq_ready_table #(.NREG(NREG), .WB_W(WB_W), .CLR_W(DISP_W)) u_rdy (
        .clk       (clk),
        .rst_n     (rst_n),
        .wb_valid  (wb_valid),
        .wb_reg    (wb_reg),
        .clr_valid (clr_valid),
        .clr_reg   (disp_dst),
        .rdy       (rdy)
    );

    for (genvar g = 0; g < DEPTH; g++) begin : g_ent
        wfq_entry_fsm #(.LAT_W(LAT_W)) u_fsm (
            .st_cur   (st_q[g]),
            .lat_cur  (lat_q[g]),
            .srcs_rdy (rdy[sa_q[g]] & rdy[sb_q[g]]),
            .st_nxt   (st_n[g]),
            .lat_nxt  (lat_n[g])
        );
        assign req[g] = (st_q[g] == ST_REQ);

        AST_COMPACT: assert property (@(posedge clk) disable iff (!rst_n)
            (CNTW'(g) >= cnt_q) == (st_q[g] == ST_FREE)) else $error("hole in queue"); // R7
    end

    wfq_select #(.N(DEPTH), .W(ISSUE_W)) u_sel (
        .clk       (clk),
        .rst_n     (rst_n),
        .req       (req),
        .grant     (grant),
        .out_valid (iss_valid),
        .out_idx   (sel_idx)
    );

    always_comb begin
        for (int k = 0; k < ISSUE_W; k++) iss_tag[k] = tag_q[sel_idx[k]];
    end

    // Collapse survivors to the front, then append the accepted lanes.
    always_comb begin
        int wr;
        wr = 0;
        for (int i = 0; i < DEPTH; i++) begin
            st_d[i]  = ST_FREE;
            lat_d[i] = '0;
            sa_d[i]  = '0;
            sb_d[i]  = '0;
            tag_d[i] = '0;
        end
        for (int i = 0; i < DEPTH; i++) begin
            if (st_q[i] != ST_FREE && !grant[i] && wr < DEPTH) begin
                st_d[wr]  = st_n[i];
                lat_d[wr] = lat_n[i];
                sa_d[wr]  = sa_q[i];
                sb_d[wr]  = sb_q[i];
                tag_d[wr] = tag_q[i];
                wr        = wr + 1;
            end
        end
        for (int l = 0; l < DISP_W; l++) begin
            if (clr_valid[l] && wr < DEPTH) begin
                st_d[wr]  = (disp_lat[l] != '0) ? ST_WAIT : ST_CHECK;
                lat_d[wr] = disp_lat[l];
                sa_d[wr]  = disp_src_a[l];
                sb_d[wr]  = disp_src_b[l];
                tag_d[wr] = disp_tag[l];
                wr        = wr + 1;
            end
        end
        cnt_d = CNTW'(wr);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            for (int i = 0; i < DEPTH; i++) begin
                st_q[i]  <= ST_FREE;
                lat_q[i] <= '0;
                sa_q[i]  <= '0;
                sb_q[i]  <= '0;
                tag_q[i] <= '0;
            end
        end else begin
            cnt_q <= cnt_d;
            for (int i = 0; i < DEPTH; i++) begin
                st_q[i]  <= st_d[i];
                lat_q[i] <= lat_d[i];
                sa_q[i]  <= sa_d[i];
                sb_q[i]  <= sb_d[i];
                tag_q[i] <= tag_d[i];
            end
        end
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CNTW'(DEPTH)) else $error("occupancy overflow"); // R2

    AST_STALL_NO_GROWTH: assert property (@(posedge clk) disable iff (!rst_n)
        disp_full |=> (cnt_q <= $past(cnt_q))) else $error("grew while full"); // R3

    AST_ISSUE_LEAVES: assert property (@(posedge clk) disable iff (!rst_n)
        (iss_valid != '0) |=> (cnt_q < CNTW'(DEPTH))) else $error("issued entry kept"); // R7
endmodule

// File: tb/wf_issue_queue_tb_top.sv
module wf_issue_queue_tb_top;
    localparam int DEPTH = 8, ISSUE_W = 4, DISP_W = 4, NREG = 32, WB_W = 2;
    localparam int LAT_W = 4, TAG_W = 8, RW = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;

    logic [DISP_W-1:0]             disp_valid = '0;
    logic [DISP_W-1:0][LAT_W-1:0]  disp_lat = '0;
    logic [DISP_W-1:0][RW-1:0]     disp_src_a = '0, disp_src_b = '0, disp_dst = '0;
    logic [DISP_W-1:0][TAG_W-1:0]  disp_tag = '0;
    logic                          disp_full;
    logic [WB_W-1:0]               wb_valid = '0;
    logic [WB_W-1:0][RW-1:0]       wb_reg = '0;
    logic [ISSUE_W-1:0]            iss_valid;
    logic [ISSUE_W-1:0][TAG_W-1:0] iss_tag;

    wf_issue_queue #(.DEPTH(DEPTH), .ISSUE_W(ISSUE_W), .DISP_W(DISP_W), .NREG(NREG),
                     .WB_W(WB_W), .LAT_W(LAT_W), .TAG_W(TAG_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .disp_valid(disp_valid), .disp_lat(disp_lat),
        .disp_src_a(disp_src_a), .disp_src_b(disp_src_b), .disp_dst(disp_dst),
        .disp_tag(disp_tag), .disp_full(disp_full), .wb_valid(wb_valid),
        .wb_reg(wb_reg), .iss_valid(iss_valid), .iss_tag(iss_tag)
    );

    int total = 0, bad = 0, cyc = 0;
    int s_v[DISP_W], s_lat[DISP_W], s_sa[DISP_W], s_sb[DISP_W], s_dst[DISP_W], s_tag[DISP_W];
    int s_wbv[WB_W], s_wbr[WB_W];
    // reference model: 0 free, 1 counting, 2 checking, 3 requesting
    int m_st[DEPTH], m_lat[DEPTH], m_sa[DEPTH], m_sb[DEPTH], m_tag[DEPTH];
    int m_cnt = 0;
    bit m_rdy[NREG];
    int iss_cyc[256], iss_lane[256], iss_n[256];

    task automatic chk(bit ok, string req, int act, int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    task automatic put(int ln, int lat, int sa, int sb, int dst, int tag);
        s_v[ln] = 1; s_lat[ln] = lat; s_sa[ln] = sa; s_sb[ln] = sb;
        s_dst[ln] = dst; s_tag[ln] = tag;
    endtask

    task automatic step();
        int k;
        int n_st[DEPTH], n_lat[DEPTH], n_sa[DEPTH], n_sb[DEPTH], n_tag[DEPTH];
        int n_cnt;
        bit gr[DEPTH];
        bit full;
        @(negedge clk);
        for (int l = 0; l < DISP_W; l++) begin
            disp_valid[l] = s_v[l][0];
            disp_lat[l] = LAT_W'(s_lat[l]);
            disp_src_a[l] = RW'(s_sa[l]);
            disp_src_b[l] = RW'(s_sb[l]);
            disp_dst[l] = RW'(s_dst[l]);
            disp_tag[l] = TAG_W'(s_tag[l]);
        end
        for (int p = 0; p < WB_W; p++) begin
            wb_valid[p] = s_wbv[p][0];
            wb_reg[p] = RW'(s_wbr[p]);
        end
        k = 0;
        for (int i = 0; i < DEPTH; i++) begin
            gr[i] = 0;
            if (i < m_cnt && m_st[i] == 3 && k < ISSUE_W) begin
                gr[i] = 1;
                chk(iss_valid[k] == 1'b1, "R6 lane valid", int'(iss_valid[k]), 1);
                chk(int'(iss_tag[k]) == m_tag[i], "R9 lane tag", int'(iss_tag[k]), m_tag[i]);
                k++;
            end
        end
        for (int j = k; j < ISSUE_W; j++)
            chk(iss_valid[j] == 1'b0, "R6 idle lane", int'(iss_valid[j]), 0);
        for (int j = 0; j < ISSUE_W; j++) begin
            if (iss_valid[j]) begin
                iss_cyc[iss_tag[j]] = cyc;
                iss_lane[iss_tag[j]] = j;
                iss_n[iss_tag[j]]++;
            end
        end
        full = (m_cnt > DEPTH - DISP_W);
        chk(disp_full == full, "R3 full flag", int'(disp_full), int'(full));
        n_cnt = 0;
        for (int i = 0; i < DEPTH; i++) n_st[i] = 0;
        for (int i = 0; i < m_cnt; i++) begin
            if (!gr[i]) begin
                n_sa[n_cnt] = m_sa[i]; n_sb[n_cnt] = m_sb[i]; n_tag[n_cnt] = m_tag[i];
                n_lat[n_cnt] = m_lat[i]; n_st[n_cnt] = m_st[i];
                if (m_st[i] == 1) begin
                    n_lat[n_cnt] = m_lat[i] - 1;
                    if (m_lat[i] == 1) n_st[n_cnt] = 2;
                end else if (m_st[i] == 2 && m_rdy[m_sa[i]] && m_rdy[m_sb[i]]) begin
                    n_st[n_cnt] = 3;
                end
                n_cnt++;
            end
        end
        if (!full) begin
            for (int l = 0; l < DISP_W; l++) begin
                if (s_v[l] != 0) begin
                    n_st[n_cnt] = (s_lat[l] > 0) ? 1 : 2;
                    n_lat[n_cnt] = s_lat[l]; n_sa[n_cnt] = s_sa[l];
                    n_sb[n_cnt] = s_sb[l]; n_tag[n_cnt] = s_tag[l];
                    n_cnt++;
                end
            end
        end
        @(posedge clk);
        cyc++;
        for (int p = 0; p < WB_W; p++) if (s_wbv[p] != 0) m_rdy[s_wbr[p]] = 1;
        if (!full) for (int l = 0; l < DISP_W; l++) if (s_v[l] != 0) m_rdy[s_dst[l]] = 0;
        m_cnt = n_cnt;
        for (int i = 0; i < DEPTH; i++) begin
            m_st[i] = n_st[i]; m_lat[i] = n_lat[i]; m_sa[i] = n_sa[i];
            m_sb[i] = n_sb[i]; m_tag[i] = n_tag[i];
        end
        for (int l = 0; l < DISP_W; l++) s_v[l] = 0;
        for (int p = 0; p < WB_W; p++) s_wbv[p] = 0;
    endtask

    task automatic finish_run();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired actual=%0d expected=0", cyc);
        finish_run();
    end

    initial begin
        int d, w;
        for (int t = 0; t < 256; t++) begin iss_cyc[t] = -1; iss_lane[t] = -1; iss_n[t] = 0; end
        for (int r = 0; r < NREG; r++) m_rdy[r] = 1;
        for (int l = 0; l < DISP_W; l++) s_v[l] = 0;
        for (int p = 0; p < WB_W; p++) s_wbv[p] = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        chk(iss_valid == '0, "R1 no issue after reset", int'(iss_valid), 0);
        chk(disp_full == 1'b0, "R1 not full after reset", int'(disp_full), 0);

        // R4 countdown and R1 all-ready table
        put(0, 3, 1, 2, 20, 10);
        put(1, 0, 5, 6, 21, 11);
        step(); d = cyc;
        repeat (8) step();
        chk(iss_cyc[10] == d + 4, "R4 issue cycle", iss_cyc[10], d + 4);
        chk(iss_cyc[11] == d + 1, "R1 sources ready at reset", iss_cyc[11], d + 1);

        // R5 precheck holds a consumer of a renamed register
        put(0, 5, 1, 1, 7, 20);
        step();
        put(0, 0, 7, 3, 22, 21);
        step();
        repeat (6) step();
        chk(iss_cyc[21] == -1, "R5 held while source not ready", iss_cyc[21], -1);
        s_wbv[0] = 1; s_wbr[0] = 7;
        step(); w = cyc;
        repeat (4) step();
        chk(iss_cyc[21] == w + 1, "R5 issue after writeback", iss_cyc[21], w + 1);

        // R8 rename clear beats a same-cycle writeback
        put(0, 8, 1, 1, 9, 30);
        s_wbv[1] = 1; s_wbr[1] = 9;
        step();
        put(0, 0, 9, 9, 23, 31);
        step();
        repeat (5) step();
        chk(iss_cyc[31] == -1, "R8 clear wins", iss_cyc[31], -1);
        s_wbv[0] = 1; s_wbr[0] = 9;
        step(); w = cyc;
        repeat (3) step();
        chk(iss_cyc[31] == w + 1, "R8 set by writeback", iss_cyc[31], w + 1);
        repeat (12) step();

        // R6 oldest-first with eight requesters
        for (int k = 0; k < 4; k++) put(k, 1, 1, 2, 24 + k, 40 + k);
        step(); d = cyc;
        for (int k = 0; k < 4; k++) put(k, 0, 1, 2, 28 + k, 44 + k);
        step();
        repeat (5) step();
        for (int k = 0; k < 4; k++) begin
            chk(iss_cyc[40 + k] == d + 2, "R6 older group first", iss_cyc[40 + k], d + 2);
            chk(iss_lane[40 + k] == k, "R6 lane order older", iss_lane[40 + k], k);
            chk(iss_cyc[44 + k] == d + 3, "R6 younger group next", iss_cyc[44 + k], d + 3);
            chk(iss_lane[44 + k] == k, "R6 lane order younger", iss_lane[44 + k], k);
        end

        // R3 fill to capacity, then an ignored dispatch
        for (int k = 0; k < 4; k++) put(k, 15, 1, 2, 10 + k, 50 + k);
        step();
        for (int k = 0; k < 4; k++) put(k, 15, 1, 2, 14 + k, 54 + k);
        step();
        #2;
        chk(disp_full == 1'b1, "R3 full at capacity", int'(disp_full), 1);
        put(0, 0, 1, 2, 18, 60);
        step();
        repeat (20) step();
        chk(iss_cyc[60] == -1, "R3 stalled group dropped", iss_cyc[60], -1);
        #2;
        chk(disp_full == 1'b0, "R7 slots freed", int'(disp_full), 0);
        for (int k = 0; k < 8; k++)
            chk(iss_n[50 + k] == 1, "R7 issued once", iss_n[50 + k], 1);

        // R2 sparse lanes appended in lane order without a gap
        put(0, 0, 1, 2, 19, 70);
        put(2, 0, 1, 2, 20, 72);
        step();
        repeat (4) step();
        chk(iss_lane[70] == 0, "R2 lane 0 first", iss_lane[70], 0);
        chk(iss_lane[72] == 1, "R2 lane 2 packed next", iss_lane[72], 1);
        chk(iss_cyc[72] == iss_cyc[70], "R2 same issue cycle", iss_cyc[72], iss_cyc[70]);
        chk(iss_n[10] == 1 && iss_n[21] == 1 && iss_n[31] == 1, "R7 single issue",
            iss_n[10] + iss_n[21] + iss_n[31], 3);
        finish_run();
    end
endmodule